// File: doc/BRIEF.md
# I2C Register-Access Master Sequencer

This block is an I2C bus master that performs a complete indexed register write or register read from a single host command. The host supplies a 7-bit device address, an 8-bit register index, a byte count, the direction and, for writes, the data bytes. The sequencer then runs the whole bus transaction without further host involvement. It generates START, repeated START and STOP, sends the address and index bytes, streams the data, and checks every acknowledge. For reads it NACKs the final byte.

Both bus lines are driven as open-drain pull-down enables. The pad logic outside the block ties each line low when its pull output is 1 and lets it float high otherwise. The SDA line level comes back in through `sda_in`. A parameter sets the SCL half-period in system clocks. Each bit is built from four equal quarter-phases, so SDA only moves while SCL is low, except at START and STOP.

A multi-byte transfer covers consecutive registers, starting at the given index. The read data is returned as a packed vector, together with a one-cycle completion pulse and an error flag.

Top module: `i2c_regseq`

## Requirements
- R1: After reset, and whenever `busy` is 0, both `scl_pull` and `sda_pull` are 0 (both lines released), `done` is 0 and `rdata` is all zeros until the first read completes.
- R2: A write command (`cmd_read`=0) produces START, the address byte `{cmd_addr,1'b0}`, `cmd_index`, then N = `cmd_len_m1`+1 data bytes taken from `cmd_wdata` byte k at bits [8k+7:8k], then STOP. Every byte is sent most significant bit first.
- R3: A read command produces START, `{cmd_addr,1'b0}`, `cmd_index`, a repeated START, `{cmd_addr,1'b1}`, then N received bytes, then STOP. Received byte k is placed in `rdata` bits [8k+7:8k]. `rdata` holds its value whenever the block is idle.
- R4: In a read, the master drives SDA low (ACK) in the ninth clock of every received byte except the last one, and leaves SDA released (NACK) on the last byte.
- R5: If any byte the master sends is not acknowledged (SDA high in the ninth clock), no further byte is sent. The master issues STOP, and `nack_err` is 1 while `done` pulses; `rdata` is left unchanged. On a fully acknowledged transfer, `nack_err` is 0 while `done` pulses.
- R6: A command presented with `cmd_valid`=1 while `busy`=0 is accepted at that clock edge, and `busy` is 1 in the following cycle. `busy` stays 1 until STOP completes, then falls in the same cycle that `done` is 1 for exactly one cycle.
- R7: A command presented while `busy`=1 is ignored. It produces no bus activity, neither during the current transaction nor after it.
- R8: During a transaction, every SCL low period lasts exactly `HALF_DIV` clocks. Every SCL high period lasts between `HALF_DIV` and `HALF_DIV`+2 clocks.
- R9: `scl_pull` and `sda_pull` never change in the same clock cycle. SDA changes while SCL is high only as a fall (START) or a rise (STOP).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_addr | input | 7 | 7-bit device address |
| cmd_index | input | 8 | First register index |
| cmd_len_m1 | input | LW | Byte count minus one |
| cmd_wdata | input | 8*MAX_BYTES | Write bytes, byte k at [8k+7:8k] |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| nack_err | output | 1 | Set when the finished transfer saw a NACK |
| rdata | output | 8*MAX_BYTES | Read bytes, byte k at [8k+7:8k] |
| scl_pull | output | 1 | 1 = hold SCL low |
| sda_pull | output | 1 | 1 = hold SDA low |
| sda_in | input | 1 | Level of the SDA line |

## Verification
The completion pulse of one transaction and the acceptance of the next command can fall in the same cycle. The bench therefore presents every following command in exactly the cycle where `done` is seen. It then judges that `busy` is high one cycle later and that the bus model decodes a complete, correctly framed second transaction, with the first one's error flag already reported. The opposite overlap is also exercised: a command is injected in mid-transaction. The bench checks that the decoded frame belongs only to the first command and that no START follows once the block is idle.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

   // Primitive bus operations executed by the bit engine
   typedef enum logic [2:0] {
      OP_NONE,
      OP_START,
      OP_STOP,
      OP_WRITE,
      OP_READ
   } op_e;

   // Transaction steps of the sequencer
   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_START,
      SQ_ADDRW,
      SQ_INDEX,
      SQ_WDATA,
      SQ_RSTART,
      SQ_ADDRR,
      SQ_RDATA,
      SQ_STOP
   } seq_e;

endpackage

// File: rtl/i2cseq_tick.sv
module i2cseq_tick #(
   parameter int QTR = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   generate
      if (QTR <= 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(QTR);
         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (clr || cnt == CW'(QTR - 1))
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick = (cnt == CW'(QTR - 1));
      end
   endgenerate

endmodule

// File: rtl/i2cseq_engine.sv
module i2cseq_engine
   import i2cseq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  op_e        op,
   input  logic [7:0] tx,
   input  logic       ack_out,
   input  logic       sda_in,
   output logic       done,
   output logic [7:0] rx,
   output logic       slv_ack,
   output logic       scl_pull,
   output logic       sda_pull
);

   logic       busy_q;
   op_e        op_q;
   logic [1:0] ph;
   logic [1:0] ph_n;
   logic [3:0] bitn;
   logic [7:0] sh;
   logic       ackout_q;
   logic       sda_low_val;
   logic       is_byte;
   logic       last_bit;

   assign ph_n     = ph + 2'd1;
   assign is_byte  = (op_q == OP_WRITE) || (op_q == OP_READ);
   assign last_bit = !is_byte || (bitn == 4'd8);

   // SDA level applied one quarter after SCL has fallen
   always_comb begin
      case (op_q)
         OP_START: sda_low_val = 1'b0;
         OP_STOP:  sda_low_val = 1'b1;
         OP_WRITE: sda_low_val = (bitn == 4'd8) ? 1'b0 : !sh[3'd7 - bitn[2:0]];
         OP_READ:  sda_low_val = (bitn == 4'd8) ? ackout_q : 1'b0;
         default:  sda_low_val = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         done     <= 1'b0;
         op_q     <= OP_NONE;
         ph       <= 2'd0;
         bitn     <= 4'd0;
         sh       <= 8'd0;
         ackout_q <= 1'b0;
         rx       <= 8'd0;
         slv_ack  <= 1'b0;
         scl_pull <= 1'b0;
         sda_pull <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy_q) begin
            if (go) begin
               busy_q   <= 1'b1;
               op_q     <= op;
               ph       <= 2'd0;
               bitn     <= 4'd0;
               sh       <= tx;
               ackout_q <= ack_out;
               scl_pull <= 1'b1;
            end
         end else if (tick) begin
            if (ph == 2'd3) begin
               if (last_bit) begin
                  busy_q <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  bitn     <= bitn + 4'd1;
                  ph       <= 2'd0;
                  scl_pull <= 1'b1;
               end
            end else begin
               ph <= ph_n;
               case (ph_n)
                  2'd1:    sda_pull <= sda_low_val;
                  2'd2:    scl_pull <= 1'b0;
                  default: begin
                     if (op_q == OP_START)
                        sda_pull <= 1'b1;
                     else if (op_q == OP_STOP)
                        sda_pull <= 1'b0;
                     else if (op_q == OP_WRITE && bitn == 4'd8)
                        slv_ack <= !sda_in;
                     else if (op_q == OP_READ && bitn != 4'd8)
                        rx <= {rx[6:0], sda_in};
                  end
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
   import i2cseq_pkg::*;
#(
   parameter  int HALF_DIV  = 8,
   parameter  int MAX_BYTES = 4,
   localparam int LW        = $clog2(MAX_BYTES),
   localparam int DW        = 8 * MAX_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic          cmd_read,
   input  logic [6:0]    cmd_addr,
   input  logic [7:0]    cmd_index,
   input  logic [LW-1:0] cmd_len_m1,
   input  logic [DW-1:0] cmd_wdata,
   output logic          busy,
   output logic          done,
   output logic          nack_err,
   output logic [DW-1:0] rdata,
   output logic          scl_pull,
   output logic          sda_pull,
   input  logic          sda_in
);

   localparam int QTR = HALF_DIV / 2;

   generate
      if (HALF_DIV < 2 || (HALF_DIV % 2) != 0) begin : g_bad_div
         $error("HALF_DIV must be an even number of at least 2");
      end
      if (MAX_BYTES < 2 || (1 << LW) != MAX_BYTES) begin : g_bad_len
         $error("MAX_BYTES must be a power of two of at least 2");
      end
   endgenerate

   seq_e          st;
   logic          pend;
   logic          lat_read;
   logic [6:0]    lat_addr;
   logic [7:0]    lat_index;
   logic [LW-1:0] lat_len;
   logic [DW-1:0] wbuf;
   logic [LW-1:0] cnt;
   logic          err_q;

   op_e           eng_op;
   logic [7:0]    eng_tx;
   logic          eng_go;
   logic          eng_done;
   logic [7:0]    eng_rx;
   logic          eng_ack;
   logic          tick;

   assign busy     = (st != SQ_IDLE);
   assign nack_err = err_q;
   assign eng_go   = pend;

   always_comb begin
      case (st)
         SQ_START, SQ_RSTART:                   eng_op = OP_START;
         SQ_ADDRW, SQ_INDEX, SQ_WDATA, SQ_ADDRR: eng_op = OP_WRITE;
         SQ_RDATA:                              eng_op = OP_READ;
         SQ_STOP:                               eng_op = OP_STOP;
         default:                               eng_op = OP_NONE;
      endcase
      case (st)
         SQ_ADDRW: eng_tx = {lat_addr, 1'b0};
         SQ_INDEX: eng_tx = lat_index;
         SQ_WDATA: eng_tx = wbuf[{cnt, 3'b000} +: 8];
         SQ_ADDRR: eng_tx = {lat_addr, 1'b1};
         default:  eng_tx = 8'd0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         pend      <= 1'b0;
         lat_read  <= 1'b0;
         lat_addr  <= '0;
         lat_index <= '0;
         lat_len   <= '0;
         wbuf      <= '0;
         cnt       <= '0;
         err_q     <= 1'b0;
         done      <= 1'b0;
         rdata     <= '0;
      end else begin
         done <= 1'b0;
         if (eng_go)
            pend <= 1'b0;
         if (st == SQ_IDLE) begin
            if (cmd_valid) begin
               lat_read  <= cmd_read;
               lat_addr  <= cmd_addr;
               lat_index <= cmd_index;
               lat_len   <= cmd_len_m1;
               wbuf      <= cmd_wdata;
               cnt       <= '0;
               err_q     <= 1'b0;
               pend      <= 1'b1;
               st        <= SQ_START;
            end
         end else if (eng_done) begin
            pend <= 1'b1;
            case (st)
               SQ_START:  st <= SQ_ADDRW;
               SQ_RSTART: st <= SQ_ADDRR;
               SQ_ADDRW:  st <= eng_ack ? SQ_INDEX : SQ_STOP;
               SQ_INDEX:  st <= !eng_ack ? SQ_STOP : (lat_read ? SQ_RSTART : SQ_WDATA);
               SQ_ADDRR:  st <= eng_ack ? SQ_RDATA : SQ_STOP;
               SQ_WDATA: begin
                  if (!eng_ack || cnt == lat_len)
                     st <= SQ_STOP;
                  else
                     cnt <= cnt + 1'b1;
               end
               SQ_RDATA: begin
                  rdata[{cnt, 3'b000} +: 8] <= eng_rx;
                  if (cnt == lat_len)
                     st <= SQ_STOP;
                  else
                     cnt <= cnt + 1'b1;
               end
               default: begin
                  st   <= SQ_IDLE;
                  pend <= 1'b0;
                  done <= 1'b1;
               end
            endcase
            if (!eng_ack && (st == SQ_ADDRW || st == SQ_INDEX ||
                             st == SQ_WDATA || st == SQ_ADDRR))
               err_q <= 1'b1;
         end
      end
   end

   i2cseq_tick #(.QTR(QTR)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (eng_go),
      .tick  (tick)
   );

   i2cseq_engine u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .go       (eng_go),
      .op       (eng_op),
      .tx       (eng_tx),
      .ack_out  (cnt != lat_len),
      .sda_in   (sda_in),
      .done     (eng_done),
      .rx       (eng_rx),
      .slv_ack  (eng_ack),
      .scl_pull (scl_pull),
      .sda_pull (sda_pull)
   );

endmodule

// File: rtl/i2c_regseq_chk.sv
module i2c_regseq_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cmd_valid,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] rdata,
   input logic          scl_pull,
   input logic          sda_pull
);

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_pull && !sda_pull));

   // R6
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy);

   // R6
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R6
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R9
   no_joint_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(scl_pull) |-> $stable(sda_pull));

   // R3
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(rdata));

endmodule

bind i2c_regseq i2c_regseq_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .busy      (busy),
   .done      (done),
   .rdata     (rdata),
   .scl_pull  (scl_pull),
   .sda_pull  (sda_pull)
);

// File: tb/sim_i2c_regseq.sv
module sim_i2c_regseq;

   localparam int HD  = 6;
   localparam int MB  = 4;
   localparam logic [6:0] SLV = 7'h3A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_read = 1'b0;
   logic [6:0]  cmd_addr = '0;
   logic [7:0]  cmd_index = '0;
   logic [1:0]  cmd_len_m1 = '0;
   logic [31:0] cmd_wdata = '0;
   logic        busy, done, nack_err, scl_pull, sda_pull;
   logic [31:0] rdata;
   logic        sl_drive = 1'b0;
   wire         scl = !scl_pull;
   wire         sda = !(sda_pull || sl_drive);

   always #5 clk = !clk;

   i2c_regseq #(.HALF_DIV(HD), .MAX_BYTES(MB)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
      .cmd_addr(cmd_addr), .cmd_index(cmd_index), .cmd_len_m1(cmd_len_m1),
      .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .nack_err(nack_err),
      .rdata(rdata), .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] init_val(input int i);
      return 8'((i * 29 + 7) & 255);
   endfunction

   // ---------------- bus slave model ----------------
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];
   logic [7:0] sl_bytes [16];
   bit         sl_macks [8];
   int nbytes = 0, nmack = 0, nstart = 0, nstop = 0, txc = 0, inj = -1;
   int bitn = 0, byte_no = 0;
   bit in_x = 0, first = 0, rdph = 0, go_rd = 0, mack_ok = 0, ack = 0;
   logic [7:0] shreg = 0, tx = 0, ptr = 0;
   logic scl_d = 1'b1, sda_d = 1'b1;

   always @(negedge clk) begin
      if (scl && scl_d && sda_d && !sda) begin
         nstart++; in_x = 1; bitn = 0; first = 1; rdph = 0; go_rd = 0;
         sl_drive = 1'b0; byte_no = 0;
      end else if (scl && scl_d && !sda_d && sda) begin
         nstop++; in_x = 0; sl_drive = 1'b0;
      end else if (in_x && scl && !scl_d) begin
         if (bitn < 8 && !rdph) shreg = {shreg[6:0], sda};
         if (bitn == 8 && rdph) begin
            sl_macks[nmack] = !sda; nmack++; mack_ok = !sda;
         end
         bitn++;
      end else if (in_x && !scl && scl_d) begin
         if (bitn == 8) begin
            if (!rdph) begin
               ack = (txc != inj);
               sl_bytes[nbytes] = shreg; nbytes++; txc++;
               if (first) begin
                  ack = ack && (shreg[7:1] == SLV);
                  first = 0; go_rd = ack && shreg[0]; mack_ok = 1;
               end else if (ack) begin
                  if (byte_no == 0) ptr = shreg;
                  else begin mem[ptr] = shreg; ptr++; end
                  byte_no++;
               end
               sl_drive = ack;
            end else sl_drive = 1'b0;
         end else if (bitn == 9) begin
            bitn = 0; rdph = go_rd;
            if (rdph && mack_ok) begin
               tx = mem[ptr]; ptr++; sl_drive = !tx[7];
            end else sl_drive = 1'b0;
         end else if (rdph && bitn >= 1 && bitn <= 7) begin
            sl_drive = !tx[7 - bitn];
         end
      end
      scl_d = scl; sda_d = sda;
   end

   // ---------------- SCL width monitor (R8) ----------------
   int run = 0, wbad = 0, wlast = 0;
   bit seg_ok = 0;
   logic scl_m = 1'b1;
   always @(negedge clk) begin
      if (done) seg_ok = 0;
      if (scl !== scl_m) begin
         if (seg_ok && busy) begin
            if (!scl_m && run != HD) begin wbad++; wlast = run; end
            if (scl_m && (run < HD || run > HD + 2)) begin wbad++; wlast = run; end
         end
         seg_ok = busy; run = 1; scl_m = scl;
      end else run++;
   end

   // ---------------- transaction task ----------------
   task automatic run_cmd(input bit rd, input logic [6:0] a, input logic [7:0] idx,
                          input int n, input logic [31:0] wd, input int injx,
                          input bit poke);
      int en, sent, guard;
      logic [31:0] prev_rd;
      prev_rd = rdata;
      sent = rd ? 3 : n + 2;
      if (a != SLV) en = 0;
      else if (injx >= 0 && injx < sent) en = injx;
      else en = -1;
      nbytes = 0; nmack = 0; nstart = 0; nstop = 0; txc = 0; inj = injx;
      wbad = 0;
      cmd_valid = 1'b1; cmd_read = rd; cmd_addr = a; cmd_index = idx;
      cmd_len_m1 = 2'(n - 1); cmd_wdata = wd;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(busy == 1'b1, "R6 busy after accept", int'(busy), 1);
      if (poke) begin
         repeat (40) @(negedge clk);
         cmd_valid = 1'b1; cmd_read = !rd; cmd_addr = a ^ 7'h11;
         cmd_index = idx + 8'd9; cmd_len_m1 = 2'd3; cmd_wdata = ~wd;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      guard = 0;
      while (!done && guard < 6000) begin @(negedge clk); guard++; end
      chk(guard < 6000, "R6 done pulse seen", guard, 0);
      chk(!busy, "R6 busy low with done", int'(busy), 0);
      chk(nack_err == (en >= 0), "R5 nack_err", int'(nack_err), int'(en >= 0));
      chk(nstop == 1, "R5 single STOP", nstop, 1);
      chk(wbad == 0, "R8 SCL period width", wlast, HD);
      chk(sl_bytes[0] == {a, 1'b0}, "R2 address byte write dir", sl_bytes[0], {a, 1'b0});
      if (en >= 0) begin
         chk(nbytes == en + 1, "R5 bytes stop after NACK", nbytes, en + 1);
         if (rd) chk(rdata == prev_rd, "R5 rdata kept on abort", rdata, prev_rd);
         if (!rd) for (int k = 0; k < en - 2; k++) exp_mem[8'(idx + k)] = wd[8*k +: 8];
      end else if (!rd) begin
         chk(nstart == 1, "R2 single START", nstart, 1);
         chk(nbytes == n + 2, "R2 byte count", nbytes, n + 2);
         chk(sl_bytes[1] == idx, "R2 index byte", sl_bytes[1], idx);
         for (int k = 0; k < n; k++) begin
            chk(sl_bytes[2 + k] == wd[8*k +: 8], "R2 data byte", sl_bytes[2 + k], wd[8*k +: 8]);
            exp_mem[8'(idx + k)] = wd[8*k +: 8];
         end
      end else begin
         chk(nstart == 2, "R3 START plus repeated START", nstart, 2);
         chk(sl_bytes[1] == idx, "R3 index byte", sl_bytes[1], idx);
         chk(sl_bytes[2] == {a, 1'b1}, "R3 address byte read dir", sl_bytes[2], {a, 1'b1});
         chk(nmack == n, "R4 master ack slots", nmack, n);
         for (int k = 0; k < n; k++) begin
            chk(sl_macks[k] == (k != n - 1), "R4 ACK all but last", sl_macks[k], k != n - 1);
            chk(rdata[8*k +: 8] == exp_mem[8'(idx + k)], "R3 read byte", rdata[8*k +: 8], exp_mem[8'(idx + k)]);
         end
      end
      if (poke) begin
         nstart = 0;
         repeat (40) @(negedge clk);
         chk(!busy && nstart == 0, "R7 busy-time command ignored", nstart, 0);
      end
   endtask

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin mem[i] = init_val(i); exp_mem[i] = init_val(i); end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !scl_pull && !sda_pull, "R1 reset outputs", {busy, done, scl_pull, sda_pull}, 0);
      chk(rdata == 0, "R1 rdata reset", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!scl_pull && !sda_pull && scl && sda, "R1 lines released", {scl, sda}, 3);
      // directed corners
      run_cmd(1'b0, SLV, 8'h10, 1, 32'h000000A5, -1, 1'b0);
      run_cmd(1'b1, SLV, 8'h10, 1, 32'h0, -1, 1'b0);
      run_cmd(1'b0, SLV, 8'hFE, 4, 32'h44332211, -1, 1'b0);
      run_cmd(1'b1, SLV, 8'hFE, 4, 32'h0, -1, 1'b0);
      run_cmd(1'b0, SLV ^ 7'h01, 8'h20, 2, 32'h0000BEEF, -1, 1'b0);
      run_cmd(1'b1, SLV ^ 7'h40, 8'h20, 2, 32'h0, -1, 1'b0);
      run_cmd(1'b0, SLV, 8'h30, 3, 32'h00C0FFEE, 1, 1'b0);
      run_cmd(1'b1, SLV, 8'h30, 3, 32'h0, 2, 1'b0);
      run_cmd(1'b0, SLV, 8'h40, 4, 32'hDEADBEEF, 5, 1'b0);
      run_cmd(1'b1, SLV, 8'h40, 4, 32'h0, -1, 1'b0);
      run_cmd(1'b0, SLV, 8'h50, 2, 32'h00005A5A, -1, 1'b1);
      run_cmd(1'b1, SLV, 8'h50, 2, 32'h0, -1, 1'b1);
      // constrained random, back-to-back with the done cycle
      for (int t = 0; t < 36; t++) begin
         bit rd;
         logic [6:0] a;
         int n, ij;
         rd = 1'($urandom_range(0, 1));
         a  = ($urandom_range(0, 7) == 0) ? (SLV ^ 7'h08) : SLV;
         n  = $urandom_range(1, MB);
         ij = ($urandom_range(0, 4) == 0) ? $urandom_range(0, rd ? 2 : n + 1) : -1;
         run_cmd(rd, a, 8'($urandom_range(0, 255)), n, $urandom, ij, 1'b0);
      end
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule